// File: doc/BRIEF.md
# Idle Wake Timer

A free-running down-counter that keeps a coarse time base for a low-power core. An input-clock prescaler divides the clock by a fixed ratio to produce an instruction-cycle tick. The counter steps down once on each tick. A small select field picks one of the upper counter bits as the wake tap. Each time the counter field below and including that bit wraps from all zeros, the block sends out a one-cycle strobe. A port register outside the block uses this strobe to clear a designated data bit, which pulls the core out of idle.

The same event sets a sticky pending flag. The flag stays set until software clears it, and a new event that lands on the same cycle as a clear keeps the flag set. An interrupt request is raised while the flag, the local timer enable and the global interrupt enable are all high. Software can neither read nor load the counter.

The default settings count 16 bits on a divide-by-ten tick, with taps at bits 11 to 15. These taps give 4,096 to 65,536 ticks between events.

Top module: `idle_wake_timer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block resets. After that edge `pend_o`, `irq_o` and `wake_clr_o` are low, the counter holds all ones and the prescaler restarts at zero.
- R2: A tick occurs once every `DIV` clock cycles. The first tick is taken at the `DIV`-th rising edge after reset is released.
- R3: Select code k in 0 to `NUM_TAPS-1` chooses counter bit `TAP_LO+k`. Events then occur every `DIV * 2^(TAP_LO+1+k)` clock cycles. With the defaults, codes 000, 001, 010, 011 and 100 give 4,096, 8,192, 16,384, 32,768 and 65,536 ticks.
- R4: Select codes from `NUM_TAPS` up to the largest code behave exactly like code `NUM_TAPS-1`. With the defaults, codes 101, 110 and 111 act as 100.
- R5: `wake_clr_o` is high for exactly one cycle per event. The first event after reset appears right after rising edge number `DIV * 2^(TAP_LO+1+k)` following release.
- R6: `pend_o` goes high on the clock edge that follows a `wake_clr_o` pulse. It never rises without one.
- R7: Once set, `pend_o` stays high until `pend_clr` is high at a clock edge, and that edge clears it.
- R8: When `pend_clr` and an event meet at the same edge, `pend_o` stays set.
- R9: `irq_o` is high exactly when `pend_o`, `tmr_en` and `glb_en` are all high.
- R10: `tmr_en` and `glb_en` have no effect on event timing, on `wake_clr_o` or on `pend_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| period_sel | input | SEL_W | Wake tap select code |
| tmr_en | input | 1 | Local timer interrupt enable |
| glb_en | input | 1 | Global interrupt enable |
| pend_clr | input | 1 | Software clear of the pending flag |
| pend_o | output | 1 | Sticky pending flag |
| irq_o | output | 1 | Interrupt request |
| wake_clr_o | output | 1 | One-cycle strobe that clears the port wake bit |

## Verification
The hardest case to reach is a software clear that lands on the same edge as a new event. That edge comes only once per full tap period, thousands of cycles apart. The bench therefore builds the block with a narrower counter and a lower tap. It watches for the strobe at the falling edge and raises `pend_clr` so that the clear meets the edge that sets the flag. The long periods and the clamped select codes are reached the same way. Each code runs from a fresh reset so that the first event lands on a cycle the bench can predict.

// File: rtl/iwt_pkg.sv
// Package: shared constants and helpers for the idle wake timer.
// Assumes: tap positions are contiguous, starting at a chosen low bit.
package iwt_pkg;

    // Default prescale ratio (input clocks per instruction tick).
    localparam int DEF_DIV      = 10;
    // Default counter width.
    localparam int DEF_CNT_W    = 16;
    // Default lowest tap bit.
    localparam int DEF_TAP_LO   = 11;
    // Default number of distinct taps.
    localparam int DEF_NUM_TAPS = 5;
    // Default select field width.
    localparam int DEF_SEL_W    = 3;

    // Map a select code to its counter bit, clamping codes above the top tap.
    function automatic int tap_for(input int code, input int lo, input int n);
        return (code < n) ? lo + code : lo + n - 1;
    endfunction

endpackage

// File: rtl/iwt_prescaler.sv
// Module: divides the input clock into a one-cycle instruction tick.
// Assumes: DIV >= 2; the tick is high in the last cycle of each DIV-cycle frame.
module iwt_prescaler #(
    parameter int DIV = iwt_pkg::DEF_DIV
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int PW = $clog2(DIV);
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] div_q;

    assign tick = (div_q == LAST);

    // Frame counter: restarts at zero on reset and after each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (tick) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + PW'(1);
        end
    end

endmodule

// File: rtl/iwt_downcounter.sv
// Module: free-running down-counter advanced by the instruction tick.
// Assumes: no load or read path; reset fills it with all ones.
module iwt_downcounter #(
    parameter int CNT_W = iwt_pkg::DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt
);
    logic [CNT_W-1:0] cnt_q;

    assign cnt = cnt_q;

    // Count state: one step down per tick, wrapping through zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '1;
        end else if (tick) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

endmodule

// File: rtl/iwt_tap_detect.sv
// Module: turns the wrap of the selected counter field into a registered pulse.
// Assumes: a wrap of bits [tap:0] from all zeros is the 0-to-1 step of bit tap;
//          select codes above the top tap are clamped by a generated table.
module iwt_tap_detect #(
    parameter int CNT_W    = iwt_pkg::DEF_CNT_W,
    parameter int TAP_LO   = iwt_pkg::DEF_TAP_LO,
    parameter int NUM_TAPS = iwt_pkg::DEF_NUM_TAPS,
    parameter int SEL_W    = iwt_pkg::DEF_SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] cnt,
    input  logic [SEL_W-1:0] sel,
    output logic             evt
);
    localparam int CODES = 2 ** SEL_W;

    logic [CODES-1:0] field_zero;
    logic             evt_q;

    // One zero-detector per select code, each bound to its clamped tap bit.
    for (genvar g = 0; g < CODES; g++) begin : g_code
        localparam int TAP = iwt_pkg::tap_for(g, TAP_LO, NUM_TAPS);
        assign field_zero[g] = (cnt[TAP:0] == '0);
    end

    assign evt = evt_q;

    // Event register: high for the one cycle after a wrapping tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_q <= 1'b0;
        end else begin
            evt_q <= tick & field_zero[sel];
        end
    end

endmodule

// File: rtl/iwt_pending.sv
// Module: sticky pending flag and gated interrupt request.
// Assumes: an event and a clear on the same edge leave the flag set.
module iwt_pending (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic clr,
    input  logic en,
    input  logic gie,
    output logic pend,
    output logic irq
);
    logic pend_q;

    assign pend = pend_q;
    assign irq  = pend_q & en & gie;

    // Pending flag: set by an event, cleared by software, set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (evt) begin
            pend_q <= 1'b1;
        end else if (clr) begin
            pend_q <= 1'b0;
        end
    end

endmodule

// File: rtl/idle_wake_timer.sv
// Module: idle wake timer top; prescaler, counter, tap detector, pending logic.
// Assumes: the port bit that the strobe clears lives outside this block.
module idle_wake_timer #(
    parameter int DIV      = iwt_pkg::DEF_DIV,
    parameter int CNT_W    = iwt_pkg::DEF_CNT_W,
    parameter int TAP_LO   = iwt_pkg::DEF_TAP_LO,
    parameter int NUM_TAPS = iwt_pkg::DEF_NUM_TAPS,
    parameter int SEL_W    = iwt_pkg::DEF_SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] period_sel,
    input  logic             tmr_en,
    input  logic             glb_en,
    input  logic             pend_clr,
    output logic             pend_o,
    output logic             irq_o,
    output logic             wake_clr_o
);
    logic             tick;
    logic [CNT_W-1:0] cnt;
    logic             evt;

    iwt_prescaler #(.DIV(DIV)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    iwt_downcounter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .cnt   (cnt)
    );

    iwt_tap_detect #(
        .CNT_W    (CNT_W),
        .TAP_LO   (TAP_LO),
        .NUM_TAPS (NUM_TAPS),
        .SEL_W    (SEL_W)
    ) u_tap (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .cnt   (cnt),
        .sel   (period_sel),
        .evt   (evt)
    );

    iwt_pending u_pnd (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (evt),
        .clr   (pend_clr),
        .en    (tmr_en),
        .gie   (glb_en),
        .pend  (pend_o),
        .irq   (irq_o)
    );

    assign wake_clr_o = evt;

endmodule

// File: rtl/iwt_checker.sv
// Module: temporal checks on the idle wake timer ports, attached by bind.
// Assumes: the minimum event spacing is one full period of the lowest tap.
module iwt_checker #(
    parameter int DIV    = iwt_pkg::DEF_DIV,
    parameter int TAP_LO = iwt_pkg::DEF_TAP_LO
) (
    input logic clk,
    input logic rst_n,
    input logic tmr_en,
    input logic glb_en,
    input logic pend_clr,
    input logic pend_o,
    input logic irq_o,
    input logic wake_clr_o
);
    localparam int MIN_GAP = DIV * (2 ** (TAP_LO + 1));
    localparam int GW      = $clog2(MIN_GAP + 1);
    localparam logic [GW-1:0] GAP_MAX = GW'(MIN_GAP);

    logic [GW-1:0] gap_q;

    // Cycles since reset or the last strobe, saturating at the minimum gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else if (wake_clr_o) begin
            gap_q <= GW'(1);
        end else if (gap_q != GAP_MAX) begin
            gap_q <= gap_q + GW'(1);
        end
    end

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_clr_o |=> !wake_clr_o); // R5
    AST_MIN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        wake_clr_o |-> (gap_q >= GAP_MAX)); // R3
    AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
        wake_clr_o |=> pend_o); // R8
    AST_PEND_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_o && !wake_clr_o) |=> !pend_o); // R6
    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !pend_clr) |=> pend_o); // R7
    AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_clr && !wake_clr_o) |=> !pend_o); // R7
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!tmr_en || !glb_en || !pend_o) |-> !irq_o); // R9

endmodule

bind idle_wake_timer iwt_checker #(.DIV(DIV), .TAP_LO(TAP_LO)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tmr_en     (tmr_en),
    .glb_en     (glb_en),
    .pend_clr   (pend_clr),
    .pend_o     (pend_o),
    .irq_o      (irq_o),
    .wake_clr_o (wake_clr_o)
);

// File: tb/idle_wake_timer_bench.sv
`timescale 1ns/1ps
module idle_wake_timer_bench;
    localparam int DIV      = 10;
    localparam int CNT_W    = 8;
    localparam int TAP_LO   = 3;
    localparam int NUM_TAPS = 5;
    localparam int SEL_W    = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [SEL_W-1:0] period_sel = '0;
    logic             tmr_en = 1'b0;
    logic             glb_en = 1'b0;
    logic             pend_clr = 1'b0;
    logic             pend_o, irq_o, wake_clr_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int t0     = 0;
    bit done   = 1'b0;

    idle_wake_timer #(
        .DIV(DIV), .CNT_W(CNT_W), .TAP_LO(TAP_LO),
        .NUM_TAPS(NUM_TAPS), .SEL_W(SEL_W)
    ) u_idle_wake_timer (
        .clk(clk), .rst_n(rst_n), .period_sel(period_sel),
        .tmr_en(tmr_en), .glb_en(glb_en), .pend_clr(pend_clr),
        .pend_o(pend_o), .irq_o(irq_o), .wake_clr_o(wake_clr_o)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Expected cycles between events for a select code (R3, R4).
    function automatic int exp_period(input int code);
        int k;
        k = (code < NUM_TAPS) ? code : NUM_TAPS - 1;
        return DIV * (1 << (TAP_LO + 1 + k));
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic finish_up;
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t0 = cyc;
    endtask

    // Wait at falling edges for a strobe; count irq mismatches while randomizing enables.
    task automatic wait_strobe(input bit rnd, output int at, output int irq_bad, output int pend_drop);
        int lim;
        bit was_pend;
        lim = 4000;
        irq_bad = 0;
        pend_drop = 0;
        at = -1;
        was_pend = pend_o;
        while (lim > 0) begin
            @(negedge clk);
            if (was_pend && !pend_o) pend_drop++;
            was_pend = pend_o;
            if (wake_clr_o) begin
                at = cyc - t0;
                break;
            end
            if (rnd) begin
                tmr_en = 1'($urandom_range(0, 1));
                glb_en = 1'($urandom_range(0, 1));
            end
            #1;
            if (irq_o !== (pend_o & tmr_en & glb_en)) irq_bad++;
            lim--;
        end
    endtask

    initial begin
        int at, at2, bad, drop, seed;
        seed = $urandom(32'd2024);
        do_reset();
        tmr_en = 1'b1;
        glb_en = 1'b1;
        @(negedge clk);
        chk(pend_o == 1'b0, "R1 pend after reset", int'(pend_o), 0);
        chk(irq_o == 1'b0, "R1 irq after reset", int'(irq_o), 0);
        chk(wake_clr_o == 1'b0, "R1 strobe after reset", int'(wake_clr_o), 0);

        // Every select code from a fresh reset: first event, width, pending, spacing.
        for (int code = 0; code < 8; code++) begin
            period_sel = SEL_W'(code);
            do_reset();
            wait_strobe(1'b1, at, bad, drop);
            chk(at == exp_period(code), (code >= NUM_TAPS) ? "R4 clamped first event" : "R5 R2 first event", at, exp_period(code));
            chk(pend_o == 1'b0, "R6 pend before strobe edge", int'(pend_o), 0);
            @(negedge clk);
            chk(wake_clr_o == 1'b0, "R5 strobe width", int'(wake_clr_o), 0);
            chk(pend_o == 1'b1, "R6 pend after strobe", int'(pend_o), 1);
            t0 = cyc - 1;
            wait_strobe(1'b1, at2, bad, drop);
            chk(at2 == exp_period(code), "R3 event spacing", at2, exp_period(code));
            chk(bad == 0, "R9 irq gating mismatches", bad, 0);
            chk(drop == 0, "R7 pend held without clear", drop, 0);
        end

        // Clear alone drops the flag and the request.
        tmr_en = 1'b1;
        glb_en = 1'b1;
        @(negedge clk);
        chk(irq_o == 1'b1, "R9 irq with all set", int'(irq_o), 1);
        pend_clr = 1'b1;
        @(negedge clk);
        pend_clr = 1'b0;
        chk(pend_o == 1'b0, "R7 clear drops pend", int'(pend_o), 0);
        chk(irq_o == 1'b0, "R9 irq after clear", int'(irq_o), 0);

        // Clear coinciding with the setting edge: set wins.
        period_sel = 3'd0;
        do_reset();
        wait_strobe(1'b0, at, bad, drop);
        pend_clr = 1'b1;
        @(negedge clk);
        pend_clr = 1'b0;
        chk(pend_o == 1'b1, "R8 set wins over clear", int'(pend_o), 1);

        // Enables held low: timing and pending unaffected, no request.
        tmr_en = 1'b0;
        glb_en = 1'b0;
        period_sel = 3'd1;
        do_reset();
        wait_strobe(1'b0, at, bad, drop);
        chk(at == exp_period(1), "R10 timing with enables low", at, exp_period(1));
        @(negedge clk);
        chk(pend_o == 1'b1, "R10 pend with enables low", int'(pend_o), 1);
        chk(irq_o == 1'b0, "R9 no irq with enables low", int'(irq_o), 0);
        glb_en = 1'b1;
        #1;
        chk(irq_o == 1'b0, "R9 no irq without local enable", int'(irq_o), 0);

        finish_up();
    end

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        finish_up();
    end

endmodule